// File: doc/BRIEF.md
# Transceiver-side control register bank with set/clear aliases

This block is the register bank that sits on the transceiver side of a low-pin-count USB link interface. A link controller reaches it through a 6-bit register address. It uses a write strobe to change a register and a read strobe to fetch one. Six read/write registers hold the mode and control state: function control, interface control, OTG control, rising-edge interrupt enable, falling-edge interrupt enable, and a scratch byte. Each of them answers at three consecutive addresses. The first address replaces the value, the second ORs the data in, and the third clears the bits that are one in the data.

The bank also returns constant vendor and product identifier bytes, a live view of five status inputs, and a debug byte that mirrors an input bus. Changes on the status inputs are caught in an interrupt latch. A latch bit is set only when its edge direction is enabled, and reading the latch clears it. The decoded control fields and an interrupt-pending flag are driven out to the rest of the transceiver.

Top module: `ulpi_phy_regbank`

## Requirements
- R1: After reset, function control reads 41h, interface control reads 00h, OTG control reads 06h, rising enable reads 1Fh, falling enable reads 00h, scratch reads 00h, the latch reads 00h and the interrupt-pending flag is low.
- R2: A write to a register's base address replaces its value. The bases are function control 04h, interface control 07h, OTG control 0Ah, rising enable 0Dh, falling enable 10h and scratch 16h.
- R3: A write to base+1 ORs the write data into the register.
- R4: A write to base+2 clears every register bit whose write-data bit is 1.
- R5: A read at any of the three addresses of a register returns its current value. Addresses 19h to 3Fh read as 00h. Read data is 00h while the read strobe is low.
- R6: Addresses 00h, 01h, 02h and 03h return vendor ID low, vendor ID high, product ID low and product ID high (defaults C3h, A5h, 08h, 0Bh). Writes to these addresses change nothing.
- R7: Address 13h returns the five status inputs in bits 4:0 and zeros in bits 7:5. Bit 4 is ID ground, bit 3 is session end, bit 2 is session valid, bit 1 is VBUS valid and bit 0 is host disconnect. Writes to 13h, 14h and 15h change nothing.
- R8: Address 15h returns the present value of the debug input bus.
- R9: Latch bit i (read at 14h) is set in the clock edge where status bit i differs from its value sampled at the previous edge. It is set on a rise only when rising-enable bit i is 1, and on a fall only when falling-enable bit i is 1. The sampled status value resets to zero. The interrupt-pending flag is the OR of the latch bits.
- R10: A read of 14h returns the latch and clears it at that clock edge. An enabled edge that arrives in the same cycle as the read stays latched.
- R11: The mode outputs decode the registers as follows: operating mode is function control bits 4:3, interface-protect disable is interface control bit 7, clock-keep is bit 3, 3-pin serial is bit 1 and 6-pin serial is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| stat_in | input | 5 | Status sources (ID ground, session end, session valid, VBUS valid, host disconnect) |
| dbg_in | input | 8 | Live signals shown by the debug register |
| func_ctrl_o | output | 8 | Function control register |
| intf_ctrl_o | output | 8 | Interface control register |
| otg_ctrl_o | output | 8 | OTG control register |
| opmode_o | output | 2 | Operating mode field |
| prot_dis_o | output | 1 | Interface-protect disable |
| clk_keep_o | output | 1 | Keep clock running in low-power state |
| serial3_o | output | 1 | 3-pin serial mode select |
| serial6_o | output | 1 | 6-pin serial mode select |
| irq_pend_o | output | 1 | Any latch bit set |

## Verification
The alias decode is driven with data patterns that overlap the register's current bits and with patterns that only partly overlap them. Because of this, replace, OR and AND-NOT each give a different result, and a swapped alias shows up as a wrong byte. The status edges are applied as rising edges with only the rising enable set, as falling edges after the falling enable is turned on, and as an edge whose enable bit was just cleared. These cases separate edge direction from level and masked edges from unmasked ones. A latch read that coincides with a new edge checks that the set takes priority over the clear on read.

// File: rtl/ulpi_regbank_pkg.sv
package ulpi_regbank_pkg;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int NUM_ALIAS = 6;
    localparam int NUM_STAT  = 5;

    localparam logic [ADDR_W-1:0] A_VID_LO = 6'h00;
    localparam logic [ADDR_W-1:0] A_VID_HI = 6'h01;
    localparam logic [ADDR_W-1:0] A_PID_LO = 6'h02;
    localparam logic [ADDR_W-1:0] A_PID_HI = 6'h03;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h13;
    localparam logic [ADDR_W-1:0] A_LATCH  = 6'h14;
    localparam logic [ADDR_W-1:0] A_DEBUG  = 6'h15;

    localparam int IDX_FUNC = 0;
    localparam int IDX_INTF = 1;
    localparam int IDX_OTG  = 2;
    localparam int IDX_ENR  = 3;
    localparam int IDX_ENF  = 4;
    localparam int IDX_SCR  = 5;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_e;

    typedef logic [NUM_ALIAS-1:0][DATA_W-1:0] regset_t;

    function automatic logic [ADDR_W-1:0] alias_base(input int idx);
        if (idx < IDX_SCR) return ADDR_W'(4 + 3 * idx);
        return 6'h16;
    endfunction

    function automatic logic [DATA_W-1:0] alias_rst(input int idx);
        case (idx)
            IDX_FUNC: return 8'h41;
            IDX_OTG:  return 8'h06;
            IDX_ENR:  return 8'h1F;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic acc_e acc_decode(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base);
        if (addr == base)               return ACC_WRITE;
        if (addr == base + ADDR_W'(1))  return ACC_SET;
        if (addr == base + ADDR_W'(2))  return ACC_CLR;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/ulpi_alias_reg.sv
module ulpi_alias_reg
    import ulpi_regbank_pkg::*;
#(
    parameter int               AW   = ADDR_W,
    parameter int               DW   = DATA_W,
    parameter logic [AW-1:0]    BASE = '0,
    parameter logic [DW-1:0]    RST  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    acc_e kind;

    always_comb kind = acc_decode(addr, BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST;
        end else if (wr_en) begin
            case (kind)
                ACC_WRITE: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLR:   q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/ulpi_irq_latch.sv
module ulpi_irq_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stat_in,
    input  logic [N-1:0] en_rise,
    input  logic [N-1:0] en_fall,
    input  logic         rd_clr,
    output logic [N-1:0] latch_o
);

    logic [N-1:0] stat_q;
    logic [N-1:0] hit;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = (stat_in[i] & ~stat_q[i] & en_rise[i]) |
                     (~stat_in[i] & stat_q[i] & en_fall[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            latch_o <= '0;
        end else begin
            stat_q  <= stat_in;
            latch_o <= (rd_clr ? '0 : latch_o) | hit;
        end
    end

endmodule

// File: rtl/ulpi_reg_rdmux.sv
module ulpi_reg_rdmux
    import ulpi_regbank_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
    parameter logic [15:0] PRODUCT_ID = 16'h0B08
) (
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  regset_t             regs,
    input  logic [NUM_STAT-1:0] stat,
    input  logic [NUM_STAT-1:0] latch,
    input  logic [DATA_W-1:0]   dbg,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (addr)
            A_VID_LO: sel = VENDOR_ID[7:0];
            A_VID_HI: sel = VENDOR_ID[15:8];
            A_PID_LO: sel = PRODUCT_ID[7:0];
            A_PID_HI: sel = PRODUCT_ID[15:8];
            A_STATUS: sel = DATA_W'(stat);
            A_LATCH:  sel = DATA_W'(latch);
            A_DEBUG:  sel = dbg;
            default: begin
                for (int i = 0; i < NUM_ALIAS; i++) begin
                    if (acc_decode(addr, alias_base(i)) != ACC_NONE) sel = regs[i];
                end
            end
        endcase
        rdata = rd ? sel : '0;
    end

endmodule

// File: rtl/ulpi_phy_regbank.sv
module ulpi_phy_regbank
    import ulpi_regbank_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
    parameter logic [15:0] PRODUCT_ID = 16'h0B08
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_STAT-1:0] stat_in,
    input  logic [DATA_W-1:0]   dbg_in,
    output logic [DATA_W-1:0]   func_ctrl_o,
    output logic [DATA_W-1:0]   intf_ctrl_o,
    output logic [DATA_W-1:0]   otg_ctrl_o,
    output logic [1:0]          opmode_o,
    output logic                prot_dis_o,
    output logic                clk_keep_o,
    output logic                serial3_o,
    output logic                serial6_o,
    output logic                irq_pend_o
);

    regset_t             regs;
    logic [NUM_STAT-1:0] latch;
    logic                latch_rd;

    for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
        ulpi_alias_reg #(
            .AW   (ADDR_W),
            .DW   (DATA_W),
            .BASE (alias_base(g)),
            .RST  (alias_rst(g))
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (reg_wr),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .q     (regs[g])
        );
    end

    assign latch_rd = reg_rd && (reg_addr == A_LATCH);

    ulpi_irq_latch #(.N(NUM_STAT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .stat_in (stat_in),
        .en_rise (regs[IDX_ENR][NUM_STAT-1:0]),
        .en_fall (regs[IDX_ENF][NUM_STAT-1:0]),
        .rd_clr  (latch_rd),
        .latch_o (latch)
    );

    ulpi_reg_rdmux #(
        .VENDOR_ID  (VENDOR_ID),
        .PRODUCT_ID (PRODUCT_ID)
    ) u_rd (
        .rd    (reg_rd),
        .addr  (reg_addr),
        .regs  (regs),
        .stat  (stat_in),
        .latch (latch),
        .dbg   (dbg_in),
        .rdata (reg_rdata)
    );

    assign func_ctrl_o = regs[IDX_FUNC];
    assign intf_ctrl_o = regs[IDX_INTF];
    assign otg_ctrl_o  = regs[IDX_OTG];
    assign opmode_o    = regs[IDX_FUNC][4:3];
    assign prot_dis_o  = regs[IDX_INTF][7];
    assign clk_keep_o  = regs[IDX_INTF][3];
    assign serial3_o   = regs[IDX_INTF][1];
    assign serial6_o   = regs[IDX_INTF][0];
    assign irq_pend_o  = |latch;

endmodule

// File: rtl/ulpi_phy_regbank_chk.sv
module ulpi_phy_regbank_chk
    import ulpi_regbank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_STAT-1:0] stat_in,
    input logic [DATA_W-1:0]   func_ctrl_o,
    input logic                irq_pend_o
);

    // R3: OR alias of function control
    assert_func_set_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 6'h05) |=> func_ctrl_o == ($past(func_ctrl_o) | $past(reg_wdata)));

    // R4: clear alias of function control
    assert_func_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 6'h06) |=> func_ctrl_o == ($past(func_ctrl_o) & ~$past(reg_wdata)));

    // R5: unimplemented space reads zero
    assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr >= 6'h19) |-> reg_rdata == 8'h00);

    // R7: status register mirrors the status inputs
    assert_status_view_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 6'h13) |-> reg_rdata == {3'b000, stat_in});

    // R9: a pending interrupt only drops through a latch read
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_pend_o && !(reg_rd && reg_addr == 6'h14)) |=> irq_pend_o);

endmodule

bind ulpi_phy_regbank ulpi_phy_regbank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .stat_in     (stat_in),
    .func_ctrl_o (func_ctrl_o),
    .irq_pend_o  (irq_pend_o)
);

// File: tb/tb_ulpi_phy_regbank.sv
module tb_ulpi_phy_regbank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] stat_in = '0;
    logic [7:0] dbg_in = '0;
    logic [7:0] func_ctrl_o, intf_ctrl_o, otg_ctrl_o;
    logic [1:0] opmode_o;
    logic       prot_dis_o, clk_keep_o, serial3_o, serial6_o, irq_pend_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ulpi_phy_regbank dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_in(stat_in), .dbg_in(dbg_in),
        .func_ctrl_o(func_ctrl_o), .intf_ctrl_o(intf_ctrl_o), .otg_ctrl_o(otg_ctrl_o),
        .opmode_o(opmode_o), .prot_dis_o(prot_dis_o), .clk_keep_o(clk_keep_o),
        .serial3_o(serial3_o), .serial6_o(serial6_o), .irq_pend_o(irq_pend_o)
    );

    // {is_read, req, addr, wdata, expected}
    localparam int NV = 34;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 4'd1, 6'h04, 8'h00, 8'h41},  // R1
        {1'b1, 4'd1, 6'h07, 8'h00, 8'h00},  // R1
        {1'b1, 4'd1, 6'h0A, 8'h00, 8'h06},  // R1
        {1'b1, 4'd1, 6'h0D, 8'h00, 8'h1F},  // R1
        {1'b1, 4'd1, 6'h10, 8'h00, 8'h00},  // R1
        {1'b1, 4'd1, 6'h16, 8'h00, 8'h00},  // R1
        {1'b1, 4'd1, 6'h14, 8'h00, 8'h00},  // R1
        {1'b0, 4'd2, 6'h04, 8'hA5, 8'h00},  // R2
        {1'b1, 4'd2, 6'h04, 8'h00, 8'hA5},  // R2
        {1'b1, 4'd5, 6'h05, 8'h00, 8'hA5},  // R5
        {1'b1, 4'd5, 6'h06, 8'h00, 8'hA5},  // R5
        {1'b0, 4'd3, 6'h05, 8'h0A, 8'h00},  // R3
        {1'b1, 4'd3, 6'h04, 8'h00, 8'hAF},  // R3
        {1'b0, 4'd4, 6'h06, 8'h21, 8'h00},  // R4
        {1'b1, 4'd4, 6'h04, 8'h00, 8'h8E},  // R4
        {1'b0, 4'd2, 6'h07, 8'h89, 8'h00},  // R2
        {1'b1, 4'd5, 6'h09, 8'h00, 8'h89},  // R5
        {1'b0, 4'd2, 6'h16, 8'h3C, 8'h00},  // R2
        {1'b0, 4'd4, 6'h18, 8'h0C, 8'h00},  // R4
        {1'b0, 4'd3, 6'h17, 8'h03, 8'h00},  // R3
        {1'b1, 4'd3, 6'h16, 8'h00, 8'h33},  // R3
        {1'b0, 4'd6, 6'h00, 8'hFF, 8'h00},  // R6
        {1'b1, 4'd6, 6'h00, 8'h00, 8'hC3},  // R6
        {1'b1, 4'd6, 6'h01, 8'h00, 8'hA5},  // R6
        {1'b1, 4'd6, 6'h02, 8'h00, 8'h08},  // R6
        {1'b1, 4'd6, 6'h03, 8'h00, 8'h0B},  // R6
        {1'b0, 4'd7, 6'h13, 8'hFF, 8'h00},  // R7
        {1'b0, 4'd7, 6'h14, 8'hFF, 8'h00},  // R7
        {1'b1, 4'd7, 6'h13, 8'h00, 8'h00},  // R7
        {1'b1, 4'd7, 6'h14, 8'h00, 8'h00},  // R7
        {1'b1, 4'd5, 6'h19, 8'h00, 8'h00},  // R5
        {1'b1, 4'd5, 6'h3F, 8'h00, 8'h00},  // R5
        {1'b0, 4'd2, 6'h0A, 8'h5A, 8'h00},  // R2
        {1'b1, 4'd5, 6'h0C, 8'h00, 8'h5A}   // R5
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [5:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0;
        #1 chk(reg_rdata, exp, req);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(func_ctrl_o, 8'h41, "R1 func_ctrl_o");
        chk({7'b0, irq_pend_o}, 8'h00, "R1 irq_pend_o");
        reg_rd = 1'b0; reg_addr = 6'h04;
        #1 chk(reg_rdata, 8'h00, "R5 read strobe low");

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VEC[i][25:22], i);
            if (VEC[i][26]) do_rd(VEC[i][21:16], VEC[i][7:0], tag);
            else            do_wr(VEC[i][21:16], VEC[i][15:8]);
        end

        // R11: function control 8Eh, interface control 89h
        @(negedge clk);
        chk({6'b0, opmode_o}, 8'h01, "R11 opmode");
        chk({4'b0, prot_dis_o, clk_keep_o, serial3_o, serial6_o}, 8'h0D, "R11 interface fields");

        // R8
        dbg_in = 8'h5A;
        do_rd(6'h15, 8'h5A, "R8 debug mirror");

        // R9: rising edges on bits 4,2,0 with rising enable 1Fh
        @(negedge clk); stat_in = 5'h15;
        do_rd(6'h13, 8'h15, "R7 live status");
        @(negedge clk);
        chk({7'b0, irq_pend_o}, 8'h01, "R9 irq after rise");
        do_rd(6'h14, 8'h15, "R9 rise latched");
        @(negedge clk);
        chk({7'b0, irq_pend_o}, 8'h00, "R10 cleared by read");

        // R9: falling edges once falling enable is set
        do_wr(6'h10, 8'h1F);
        @(negedge clk); stat_in = 5'h00;
        do_rd(6'h14, 8'h15, "R9 fall latched");

        // R10: edge in the same cycle as the latch read
        @(negedge clk);
        reg_addr = 6'h14; reg_rd = 1'b1; stat_in = 5'h02;
        #1 chk(reg_rdata, 8'h00, "R10 read before edge");
        @(posedge clk); #1 reg_rd = 1'b0;
        do_rd(6'h14, 8'h02, "R10 edge survives read");

        // R9: masked rising edge on bit 3
        do_wr(6'h0F, 8'h08);
        @(negedge clk); stat_in = 5'h0A;
        @(negedge clk);
        chk({7'b0, irq_pend_o}, 8'h00, "R9 masked edge irq");
        do_rd(6'h14, 8'h00, "R9 masked edge latch");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule